// File: doc/BRIEF.md
# Main-CPU Byte Write Decoder

This block sits on the write path of a 16-bit main processor that has a 24-bit address space. On every cycle in which the write strobe is high, it classifies the address and sends the byte to exactly one destination. The destinations are work RAM, the sound-CPU address window, the I/O register port, the video processor, the tone generator and an optional battery-backed save RAM. Two addresses instead update control state that decides whether the sound CPU owns its bus and whether it is held in reset. Writes that match no destination raise a one-cycle unhandled flag.

All outputs are registered. A write presented in cycle N shows up on the target strobes, addresses and control outputs after the clock edge that ends cycle N. Strobes last one cycle. The save-RAM window is set at run time by an enable, a start and an end address, and a halving mode in which only every other byte of the window reaches storage.

Sound-CPU reset control is a two-state machine. In state SC_HELD the sound CPU is in reset; this is the reset state. In state SC_RUN it is released. The transition SC_HELD to SC_RUN is taken on a write to the reset-control address with data bit 0 set. The transition SC_RUN to SC_HELD is taken on a write there with bit 0 clear. A write with bit 0 clear made while already in SC_HELD stays in SC_HELD. Every write with bit 0 clear, in either state, issues a one-cycle soft-reset pulse.

Top module: `byte_write_decoder`

## Requirements
- R1: Only the low 24 bits of the incoming address take part in decoding. Address bits above bit 23 have no effect on the target or on any output address.
- R2: An address at or above 0xE00000 pulses the work-RAM strobe, with work-RAM address = address[15:0] and the byte on the shared data output.
- R3: An address whose bits [23:16] equal 0xA0 (below work RAM) pulses the sound-window strobe, with sound address = address[14:0].
- R4: Addresses 0xA10000 through 0xA1001F pulse the I/O strobe, with I/O register index = address[4:0].
- R5: A write to 0xA11100 loads the bus-grant output with data bit 0. Bus grant is 0 after reset and changes on no other write.
- R6: A write to 0xA11200 with data bit 0 clear moves to SC_HELD (sound reset output 1) and pulses soft-reset for one cycle. With bit 0 set it moves to SC_RUN (reset output 0) and gives no pulse. After reset the state is SC_HELD with no pulse.
- R7: Addresses 0xC00000 through 0xC0000F pulse the video strobe, with register select = address[4:0] with bit 0 forced to 0 and a 16-bit word holding the byte in both halves.
- R8: Odd addresses 0xC00011, 0xC00013, 0xC00015 and 0xC00017 pulse the tone-generator strobe. The even addresses between them do not.
- R9: With save RAM enabled and start <= address < end, the save-RAM strobe pulses with index address-start, or (address-start)>>1 when halving mode is 1, truncated to the index width.
- R10: The save-RAM-modified flag is 0 after reset, is 1 from the cycle of any save-RAM strobe onward, and never clears until reset.
- R11: Decoding priority is work RAM, sound window, I/O, bus grant, sound reset, video, tone, then save RAM. An address matching several regions goes only to the first.
- R12: A write that matches nothing pulses the unhandled flag. At most one of the seven strobes (six targets plus unhandled) is high in any cycle, and all are low in the cycle after a cycle without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_IN_W | Write address (only bits 23:0 decoded) |
| wr_data | input | 8 | Write data byte |
| sram_en | input | 1 | Save-RAM window enable |
| sram_start | input | 24 | Save-RAM window first address |
| sram_end | input | 24 | Save-RAM window end address (exclusive) |
| sram_half | input | 1 | Every-other-byte (halving) mode |
| wr_byte | output | 8 | Registered data byte for all targets |
| wram_we | output | 1 | Work-RAM write strobe |
| wram_addr | output | 16 | Work-RAM address |
| snd_we | output | 1 | Sound-window write strobe |
| snd_addr | output | 15 | Sound-window address |
| io_we | output | 1 | I/O register write strobe |
| io_addr | output | 5 | I/O register index |
| vid_we | output | 1 | Video write strobe |
| vid_sel | output | 5 | Video register select (bit 0 is 0) |
| vid_word | output | 16 | Byte duplicated into both halves |
| tone_we | output | 1 | Tone-generator write strobe |
| sram_we | output | 1 | Save-RAM write strobe |
| sram_addr | output | SRAM_AW | Save-RAM byte index |
| sram_dirty | output | 1 | Sticky save-RAM-modified flag |
| bus_grant | output | 1 | Main CPU owns the sound bus |
| snd_reset | output | 1 | Sound CPU held in reset |
| snd_reset_pulse | output | 1 | One-cycle soft-reset pulse |
| unhandled | output | 1 | One-cycle flag for an unmatched write |

## Verification
The bench builds the block with a 32-bit input address and a 6-bit save-RAM index, so a 64-byte window can be covered address by address in both modes. The small index width also makes the truncation of R9 visible. The sweeps cover every address in the video and tone stretch, the edges of each fixed region, and addresses with set upper bits. They also place the save-RAM window on top of the video and work-RAM regions, so the priority order of R11 is exercised rather than assumed.

// File: rtl/wdec_pkg.sv
package wdec_pkg;

    localparam int DEC_AW = 24;

    typedef enum logic [3:0] {
        T_WRAM,
        T_SND,
        T_IO,
        T_GRANT,
        T_SRST,
        T_VID,
        T_TONE,
        T_SRAM,
        T_NONE
    } tgt_e;

    typedef enum logic {
        SC_HELD,
        SC_RUN
    } snd_st_e;

    localparam logic [DEC_AW-1:0] WRAM_BASE = 24'hE00000;
    localparam logic [7:0]        SNDWIN_HI = 8'hA0;
    localparam logic [DEC_AW-1:0] IO_FIRST  = 24'hA10000;
    localparam logic [DEC_AW-1:0] IO_LAST   = 24'hA1001F;
    localparam logic [DEC_AW-1:0] GRANT_ADR = 24'hA11100;
    localparam logic [DEC_AW-1:0] SRST_ADR  = 24'hA11200;
    localparam logic [DEC_AW-1:0] VID_FIRST = 24'hC00000;
    localparam logic [DEC_AW-1:0] VID_LAST  = 24'hC0000F;
    localparam logic [DEC_AW-1:0] TONE_FIRST = 24'hC00011;
    localparam logic [DEC_AW-1:0] TONE_LAST  = 24'hC00017;

endpackage

// File: rtl/wdec_region_match.sv
module wdec_region_match
    import wdec_pkg::*;
(
    input  logic [DEC_AW-1:0] addr,
    input  logic              sram_en,
    input  logic [DEC_AW-1:0] sram_start,
    input  logic [DEC_AW-1:0] sram_end,
    output tgt_e              tgt
);

    logic in_wram, in_snd, in_io, in_grant, in_srst, in_vid, in_tone, in_sram;

    always_comb begin
        in_wram  = (addr >= WRAM_BASE);
        in_snd   = (addr[DEC_AW-1:16] == SNDWIN_HI);
        in_io    = (addr >= IO_FIRST) && (addr <= IO_LAST);
        in_grant = (addr == GRANT_ADR);
        in_srst  = (addr == SRST_ADR);
        in_vid   = (addr >= VID_FIRST) && (addr <= VID_LAST);
        in_tone  = (addr >= TONE_FIRST) && (addr <= TONE_LAST) && addr[0];
        in_sram  = sram_en && (addr >= sram_start) && (addr < sram_end);
    end

    always_comb begin
        if (in_wram)       tgt = T_WRAM;
        else if (in_snd)   tgt = T_SND;
        else if (in_io)    tgt = T_IO;
        else if (in_grant) tgt = T_GRANT;
        else if (in_srst)  tgt = T_SRST;
        else if (in_vid)   tgt = T_VID;
        else if (in_tone)  tgt = T_TONE;
        else if (in_sram)  tgt = T_SRAM;
        else               tgt = T_NONE;
    end

endmodule

// File: rtl/wdec_sram_map.sv
module wdec_sram_map
    import wdec_pkg::*;
#(
    parameter int SRAM_AW = 16
) (
    input  logic [DEC_AW-1:0]  addr,
    input  logic [DEC_AW-1:0]  sram_start,
    input  logic               sram_half,
    output logic [SRAM_AW-1:0] idx
);

    logic [DEC_AW-1:0] offset;

    assign offset = addr - sram_start;

    generate
        if (SRAM_AW + 1 < DEC_AW) begin : g_trunc
            logic unused_off_hi;
            assign unused_off_hi = ^offset[DEC_AW-1:SRAM_AW+1];
        end
    endgenerate

    always_comb begin
        if (sram_half) idx = offset[SRAM_AW:1];
        else           idx = offset[SRAM_AW-1:0];
    end

endmodule

// File: rtl/wdec_snd_ctrl.sv
module wdec_snd_ctrl
    import wdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic grant_we,
    input  logic srst_we,
    input  logic bit0,
    output logic bus_grant,
    output logic snd_reset,
    output logic rst_pulse
);

    snd_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SC_HELD;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SC_HELD: if (srst_we && bit0)  st_d = SC_RUN;
            SC_RUN:  if (srst_we && !bit0) st_d = SC_HELD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_grant <= 1'b0;
            rst_pulse <= 1'b0;
        end else begin
            rst_pulse <= srst_we && !bit0;
            if (grant_we) bus_grant <= bit0;
        end
    end

    assign snd_reset = (st_q == SC_HELD);

    // R6: a soft-reset pulse only appears while the machine is in SC_HELD
    a_r6_pulse_in_held: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> (st_q == SC_HELD));

    // R5: without a grant write the grant bit keeps its value
    a_r5_grant_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_we |=> $stable(bus_grant));

endmodule

// File: rtl/byte_write_decoder.sv
module byte_write_decoder
    import wdec_pkg::*;
#(
    parameter int ADDR_IN_W = 32,
    parameter int SRAM_AW   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_IN_W-1:0] wr_addr,
    input  logic [7:0]           wr_data,
    input  logic                 sram_en,
    input  logic [23:0]          sram_start,
    input  logic [23:0]          sram_end,
    input  logic                 sram_half,
    output logic [7:0]           wr_byte,
    output logic                 wram_we,
    output logic [15:0]          wram_addr,
    output logic                 snd_we,
    output logic [14:0]          snd_addr,
    output logic                 io_we,
    output logic [4:0]           io_addr,
    output logic                 vid_we,
    output logic [4:0]           vid_sel,
    output logic [15:0]          vid_word,
    output logic                 tone_we,
    output logic                 sram_we,
    output logic [SRAM_AW-1:0]   sram_addr,
    output logic                 sram_dirty,
    output logic                 bus_grant,
    output logic                 snd_reset,
    output logic                 snd_reset_pulse,
    output logic                 unhandled
);

    logic [DEC_AW-1:0]  a24;
    tgt_e               tgt;
    logic [SRAM_AW-1:0] sram_idx;

    assign a24 = wr_addr[DEC_AW-1:0];

    generate
        if (ADDR_IN_W > DEC_AW) begin : g_hi
            logic unused_addr_hi;
            assign unused_addr_hi = ^wr_addr[ADDR_IN_W-1:DEC_AW];
        end
    endgenerate

    wdec_region_match u_match (
        .addr       (a24),
        .sram_en    (sram_en),
        .sram_start (sram_start),
        .sram_end   (sram_end),
        .tgt        (tgt)
    );

    wdec_sram_map #(.SRAM_AW(SRAM_AW)) u_map (
        .addr       (a24),
        .sram_start (sram_start),
        .sram_half  (sram_half),
        .idx        (sram_idx)
    );

    wdec_snd_ctrl u_snd (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant_we  (wr_en && (tgt == T_GRANT)),
        .srst_we   (wr_en && (tgt == T_SRST)),
        .bit0      (wr_data[0]),
        .bus_grant (bus_grant),
        .snd_reset (snd_reset),
        .rst_pulse (snd_reset_pulse)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wram_we   <= 1'b0;
            snd_we    <= 1'b0;
            io_we     <= 1'b0;
            vid_we    <= 1'b0;
            tone_we   <= 1'b0;
            sram_we   <= 1'b0;
            unhandled <= 1'b0;
        end else begin
            wram_we   <= 1'b0;
            snd_we    <= 1'b0;
            io_we     <= 1'b0;
            vid_we    <= 1'b0;
            tone_we   <= 1'b0;
            sram_we   <= 1'b0;
            unhandled <= 1'b0;
            if (wr_en) begin
                unique case (tgt)
                    T_WRAM:  wram_we   <= 1'b1;
                    T_SND:   snd_we    <= 1'b1;
                    T_IO:    io_we     <= 1'b1;
                    T_VID:   vid_we    <= 1'b1;
                    T_TONE:  tone_we   <= 1'b1;
                    T_SRAM:  sram_we   <= 1'b1;
                    T_NONE:  unhandled <= 1'b1;
                    T_GRANT, T_SRST: ;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_byte   <= '0;
            wram_addr <= '0;
            snd_addr  <= '0;
            io_addr   <= '0;
            vid_sel   <= '0;
            vid_word  <= '0;
            sram_addr <= '0;
        end else if (wr_en) begin
            wr_byte   <= wr_data;
            wram_addr <= a24[15:0];
            snd_addr  <= a24[14:0];
            io_addr   <= a24[4:0];
            vid_sel   <= {a24[4:1], 1'b0};
            vid_word  <= {wr_data, wr_data};
            sram_addr <= sram_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          sram_dirty <= 1'b0;
        else if (wr_en && (tgt == T_SRAM))   sram_dirty <= 1'b1;
    end

    // R12: never more than one strobe per cycle
    a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wram_we, snd_we, io_we, vid_we, tone_we, sram_we, unhandled}));

    // R12: an idle cycle leaves every strobe low in the next one
    a_r12_quiet_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !(wram_we || snd_we || io_we || vid_we || tone_we ||
                     sram_we || unhandled || snd_reset_pulse));

    // R10: modified flag never clears
    a_r10_dirty_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dirty |=> sram_dirty);

    // R10: a save-RAM strobe is always accompanied by the flag
    a_r10_dirty_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> sram_dirty);

endmodule

// File: tb/byte_write_decoder_bench.sv
module byte_write_decoder_bench;

    localparam int AIW = 32;
    localparam int SAW = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [AIW-1:0]  wr_addr = '0;
    logic [7:0]      wr_data = '0;
    logic            sram_en = 1'b0;
    logic [23:0]     sram_start = '0;
    logic [23:0]     sram_end = '0;
    logic            sram_half = 1'b0;
    logic [7:0]      wr_byte;
    logic            wram_we, snd_we, io_we, vid_we, tone_we, sram_we;
    logic [15:0]     wram_addr;
    logic [14:0]     snd_addr;
    logic [4:0]      io_addr, vid_sel;
    logic [15:0]     vid_word;
    logic [SAW-1:0]  sram_addr;
    logic            sram_dirty, bus_grant, snd_reset, snd_reset_pulse, unhandled;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;
    bit exp_grant = 0;
    bit exp_held = 1;
    bit exp_dirty = 0;

    always #2.5 clk = ~clk;

    byte_write_decoder #(.ADDR_IN_W(AIW), .SRAM_AW(SAW)) u_byte_write_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sram_en(sram_en), .sram_start(sram_start), .sram_end(sram_end),
        .sram_half(sram_half), .wr_byte(wr_byte), .wram_we(wram_we),
        .wram_addr(wram_addr), .snd_we(snd_we), .snd_addr(snd_addr), .io_we(io_we),
        .io_addr(io_addr), .vid_we(vid_we), .vid_sel(vid_sel), .vid_word(vid_word),
        .tone_we(tone_we), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_dirty(sram_dirty), .bus_grant(bus_grant), .snd_reset(snd_reset),
        .snd_reset_pulse(snd_reset_pulse), .unhandled(unhandled)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks = checks + 1;
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            finish_run();
        end
    end

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // target codes: 0 wram 1 snd 2 io 3 grant 4 srst 5 vid 6 tone 7 sram 8 none
    function automatic int exp_tgt(logic [23:0] a);
        if (a >= 24'hE00000) return 0;
        if (a[23:16] == 8'hA0) return 1;
        if (a >= 24'hA10000 && a <= 24'hA1001F) return 2;
        if (a == 24'hA11100) return 3;
        if (a == 24'hA11200) return 4;
        if (a >= 24'hC00000 && a <= 24'hC0000F) return 5;
        if (a >= 24'hC00011 && a <= 24'hC00017 && a[0]) return 6;
        if (sram_en && a >= sram_start && a < sram_end) return 7;
        return 8;
    endfunction

    function automatic logic [6:0] mask_of(int t);
        case (t)
            0: return 7'b0000001;
            1: return 7'b0000010;
            2: return 7'b0000100;
            5: return 7'b0001000;
            6: return 7'b0010000;
            7: return 7'b0100000;
            8: return 7'b1000000;
            default: return 7'b0000000;
        endcase
    endfunction

    function automatic string req_of(int t);
        case (t)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            7: return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic wr_chk(logic [AIW-1:0] a, logic [7:0] d, string tag);
        int t;
        logic [6:0] obs;
        logic [6:0] em;
        logic [23:0] off;
        logic [SAW-1:0] idx;
        t = exp_tgt(a[23:0]);
        em = mask_of(t);
        off = a[23:0] - sram_start;
        idx = sram_half ? off[SAW:1] : off[SAW-1:0];
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (t == 3) exp_grant = d[0];
        if (t == 4) exp_held = !d[0];
        if (t == 7) exp_dirty = 1;
        obs = {unhandled, sram_we, tone_we, vid_we, io_we, snd_we, wram_we};
        chk(obs == em, {req_of(t), " R11 strobe ", tag}, 64'(obs), 64'(em));
        case (t)
            0: chk(wram_addr == a[15:0] && wr_byte == d, "R2 payload",
                   {wram_addr, wr_byte}, {a[15:0], d});
            1: chk(snd_addr == a[14:0] && wr_byte == d, "R3 payload",
                   {snd_addr, wr_byte}, {a[14:0], d});
            2: chk(io_addr == a[4:0], "R4 payload", 64'(io_addr), 64'(a[4:0]));
            5: chk(vid_sel == {a[4:1], 1'b0} && vid_word == {d, d}, "R7 payload",
                   {vid_sel, vid_word}, {a[4:1], 1'b0, d, d});
            6: chk(wr_byte == d, "R8 payload", 64'(wr_byte), 64'(d));
            7: chk(sram_addr == idx && wr_byte == d, "R9 payload",
                   {sram_addr, wr_byte}, {idx, d});
            default: ;
        endcase
        chk(bus_grant == exp_grant && snd_reset == exp_held &&
            snd_reset_pulse == (t == 4 && !d[0]) && sram_dirty == exp_dirty,
            "R5 R6 R10 control", {bus_grant, snd_reset, snd_reset_pulse, sram_dirty},
            {exp_grant, exp_held, (t == 4 && !d[0]), exp_dirty});
        @(negedge clk);
        obs = {unhandled, sram_we, tone_we, vid_we, io_we, snd_we, wram_we};
        chk(obs == 7'd0 && !snd_reset_pulse, "R12 one-cycle strobe",
            {obs, snd_reset_pulse}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({wram_we, snd_we, io_we, vid_we, tone_we, sram_we, unhandled} == 0,
            "R12 reset strobes", 64'(unhandled), 64'd0);
        chk(bus_grant == 0 && snd_reset == 1 && snd_reset_pulse == 0,
            "R5 R6 reset state", {bus_grant, snd_reset, snd_reset_pulse}, 64'b010);
        chk(sram_dirty == 0, "R10 reset dirty", 64'(sram_dirty), 64'd0);

        // R1: upper address bits ignored
        wr_chk(32'hABE01234, 8'h5A, "R1 high bits wram");
        wr_chk(32'hFFA07FFE, 8'h11, "R1 high bits snd");
        wr_chk(32'h01C00004, 8'h22, "R1 high bits vid");
        // R2 boundaries
        wr_chk(32'h00DFFFFF, 8'h01, "below wram");
        wr_chk(32'h00E00000, 8'h02, "wram first");
        wr_chk(32'h00FFFFFF, 8'h03, "wram last");
        // R3 window samples
        for (int i = 0; i < 16; i++)
            wr_chk(32'h00A00000 + i * 32'h0FF3, 8'(i * 7), "snd sweep");
        wr_chk(32'h009FFFFF, 8'h04, "below snd");
        // R4 edges
        for (int i = -2; i < 34; i++)
            wr_chk(32'h00A10000 + i, 8'(i), "io sweep");
        // R5 grant
        wr_chk(32'h00A11100, 8'h01, "grant set");
        wr_chk(32'h00A110FF, 8'h00, "near grant");
        wr_chk(32'h00A11101, 8'h00, "near grant");
        wr_chk(32'h00A11100, 8'hFE, "grant clear");
        wr_chk(32'h00A11100, 8'h03, "grant set again");
        // R6 reset state machine
        wr_chk(32'h00A11200, 8'h00, "held->held pulse");
        wr_chk(32'h00A11200, 8'h01, "held->run");
        wr_chk(32'h00A11200, 8'hFF, "run->run");
        wr_chk(32'h00A11201, 8'h00, "near reset reg");
        wr_chk(32'h00A11200, 8'h02, "run->held pulse");
        wr_chk(32'h00A11200, 8'h81, "held->run");
        // R7 R8 full sweep of the video/tone stretch
        for (int i = 0; i < 32; i++)
            wr_chk(32'h00C00000 + i, 8'(8'hA5 ^ i), "vid tone sweep");
        wr_chk(32'h00000000, 8'h09, "zero unmatched");
        wr_chk(32'h00100000, 8'h0A, "unmatched");
        chk(sram_dirty == 0, "R10 still clear", 64'(sram_dirty), 64'd0);

        // R9 save RAM disabled: unhandled
        sram_start = 24'h200000; sram_end = 24'h200040;
        wr_chk(32'h00200004, 8'h33, "sram disabled");
        // R9 full window, both modes
        sram_en = 1'b1;
        for (int m = 0; m < 2; m++) begin
            sram_half = m[0];
            for (int i = -2; i < 66; i++)
                wr_chk(32'h00200000 + i, 8'(i + m), "sram sweep");
        end
        // R9 index truncation beyond width
        sram_half = 1'b0;
        sram_end = 24'h200100;
        wr_chk(32'h002000C5, 8'h44, "sram wrap index");
        sram_half = 1'b1;
        wr_chk(32'h002000C5, 8'h45, "sram wrap half");
        // R11 overlap: window covering video/tone and work RAM
        sram_start = 24'hBFFFF0; sram_end = 24'hC00020; sram_half = 1'b0;
        for (int i = -4; i < 34; i++)
            wr_chk(32'h00C00000 + i, 8'(i), "overlap vid");
        sram_start = 24'hA0FFF0; sram_end = 24'hA11300;
        wr_chk(32'h00A10010, 8'h55, "overlap io");
        wr_chk(32'h00A11100, 8'h00, "overlap grant");
        wr_chk(32'h00A11200, 8'h00, "overlap reset");
        wr_chk(32'h00A11180, 8'h56, "overlap gap");
        sram_start = 24'hDFFF00; sram_end = 24'hFFFFFF;
        wr_chk(32'h00E00010, 8'h66, "overlap wram");
        wr_chk(32'h00DFFFF0, 8'h67, "sram below wram");
        // R10 sticky after unrelated traffic
        sram_en = 1'b0;
        wr_chk(32'h00000002, 8'h00, "after sram");
        repeat (3) @(negedge clk);
        chk(sram_dirty == 1, "R10 sticky", 64'(sram_dirty), 64'd1);
        finish_run();
    end

endmodule